// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses whether a conditional branch will be taken. Two history-based guesses are formed for every fetch address. The first comes from a global table of 2-bit counters, addressed by the global outcome history XORed with address bits. The second comes from a per-branch history register, whose contents address a separate table of 2-bit counters. A third table of 2-bit counters, addressed by the branch address, learns for each branch which of the two guesses to trust. The lookup is combinational, so the guess is ready in the same cycle as the fetch address.

The lookup also returns a snapshot word that the pipeline carries with the branch until it resolves. At resolution the pipeline presents the branch address, the real outcome and that snapshot on the update port, and all three tables are trained from it. The global history is advanced speculatively with each guess. When the real outcome differs from the guess recorded in the snapshot, the history is rebuilt from the snapshot, so fetch can restart on the correct path with a clean history.

Top module: `tournament_predictor`

## Requirements
- R1: After reset every counter in the three tables holds 01, every per-branch history and the global history hold zero, so any lookup yields a snapshot of all zeros and a not-taken guess.
- R2: A guess is the most significant bit of the selected counter (1 = taken). The snapshot layout is bit 22 final guess, bit 21 global guess, bit 20 local guess, bits 19:10 global history used, bits 9:0 per-branch history used.
- R3: Each counter moves up by one on a taken outcome and down by one on a not-taken outcome, holding at 3 and at 0.
- R4: The global table is addressed by the global history XOR address bits 11:2; training uses the global history stored in the snapshot.
- R5: The per-branch history is selected by address bits 9:2; on update it shifts in the real outcome at bit 0, and training of the local table uses the history stored in the snapshot.
- R6: A lookup with valid high shifts the final guess into bit 0 of the global history; with valid low the history is unchanged.
- R7: The chooser is addressed by address bits 11:2; its bit 1 set selects the global guess. When the two guesses in the snapshot differ, it steps toward the one that matched the real outcome.
- R8: When the two guesses in the snapshot agree, the chooser entry does not change.
- R9: An update whose outcome differs from the snapshot's final guess sets the global history to the snapshot history shifted left by one with the real outcome at bit 0.
- R10: A repair in a cycle that also has a valid lookup wins; the lookup's shift is discarded.
- R11: A lookup in the same cycle as an update to the same counter returns the value before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup is a real fetch; advances the global history |
| lk_pc | input | 32 | Fetch address to predict |
| lk_taken | output | 1 | Direction guess, 1 = taken |
| lk_snap | output | 23 | Snapshot to carry with the branch |
| up_valid | input | 1 | Resolved branch present |
| up_pc | input | 32 | Address of the resolved branch |
| up_taken | input | 1 | Real outcome |
| up_snap | input | 23 | Snapshot returned at lookup |

## Verification
The hardest situations to reach are a specific global-table entry under a non-zero history and a history repair colliding with a live lookup. The update port trusts the snapshot it is given, so the stimulus crafts snapshots that aim training at chosen entries, and it uses deliberate mispredicts to load an arbitrary global history before probing the XOR addressing. Probes with lookup valid low read the tables without disturbing the history, which lets hysteresis, chooser steps and the pre-update read be observed one cycle at a time.

// File: rtl/tp_pkg.sv
package tp_pkg;

  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_WEAK_NT = 2'b01;

  // saturating step of a 2-bit direction counter
  function automatic ctr_t ctr_step(input ctr_t cur, input logic up);
    ctr_t nxt;
    if (up) nxt = (cur == 2'b11) ? cur : cur + 2'b01;
    else    nxt = (cur == 2'b00) ? cur : cur - 2'b01;
    return nxt;
  endfunction

endpackage

// File: rtl/tp_rst_sync.sv
module tp_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= 2'b00;
    else          sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/tp_ctr_table.sv
module tp_ctr_table #(
  parameter int ENTRIES = 1024,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output tp_pkg::ctr_t     rd_ctr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_up
);
  import tp_pkg::*;

  ctr_t mem_q [ENTRIES];
  ctr_t wr_val;

  assign rd_ctr = mem_q[rd_idx];

  always_comb begin
    wr_val = ctr_step(mem_q[wr_idx], wr_up);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) mem_q[i] <= CTR_WEAK_NT;
    end else if (wr_en) begin
      mem_q[wr_idx] <= wr_val;
    end
  end
endmodule

// File: rtl/tp_local_hist.sv
module tp_local_hist #(
  parameter int COUNT  = 256,
  parameter int HIST_W = 10,
  parameter int IDX_W  = $clog2(COUNT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [HIST_W-1:0] rd_hist,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_bit
);
  logic [HIST_W-1:0] hist_q [COUNT];
  logic [HIST_W-1:0] wr_val;

  assign rd_hist = hist_q[rd_idx];

  always_comb begin
    wr_val = {hist_q[wr_idx][HIST_W-2:0], wr_bit};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < COUNT; i++) hist_q[i] <= '0;
    end else if (wr_en) begin
      hist_q[wr_idx] <= wr_val;
    end
  end
endmodule

// File: rtl/tp_global_hist.sv
module tp_global_hist #(
  parameter int HIST_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              shift_bit,
  input  logic              repair_en,
  input  logic [HIST_W-2:0] repair_base,
  input  logic              repair_bit,
  output logic [HIST_W-1:0] hist_o
);
  logic [HIST_W-1:0] hist_q, hist_d;
  logic              hist_en;

  always_comb begin
    hist_en = repair_en | shift_en;
    hist_d  = hist_q;
    if (repair_en)     hist_d = {repair_base, repair_bit};
    else if (shift_en) hist_d = {hist_q[HIST_W-2:0], shift_bit};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hist_q <= '0;
    else if (hist_en) hist_q <= hist_d;
  end

  assign hist_o = hist_q;
endmodule

// File: rtl/tournament_predictor.sv
module tournament_predictor #(
  parameter int PC_W            = 32,
  parameter int GHIST_W         = 10,
  parameter int PHT_ENTRIES     = 1024,
  parameter int LHR_COUNT       = 256,
  parameter int LHR_W           = 10,
  parameter int CHOOSER_ENTRIES = 1024,
  parameter int SNAP_W          = 3 + GHIST_W + LHR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [PC_W-1:0]   lk_pc,
  output logic              lk_taken,
  output logic [SNAP_W-1:0] lk_snap,
  input  logic              up_valid,
  input  logic [PC_W-1:0]   up_pc,
  input  logic              up_taken,
  input  logic [SNAP_W-1:0] up_snap
);
  import tp_pkg::*;

  localparam int PHT_IW  = $clog2(PHT_ENTRIES);
  localparam int LHR_IW  = $clog2(LHR_COUNT);
  localparam int CH_IW   = $clog2(CHOOSER_ENTRIES);
  localparam int LPHT_N  = 1 << LHR_W;
  localparam int TOP_IW  = (PHT_IW > CH_IW) ? PHT_IW : CH_IW;
  localparam int S_PRED  = SNAP_W - 1;
  localparam int S_GLOB  = SNAP_W - 2;
  localparam int S_LOC   = SNAP_W - 3;
  localparam int S_GH_LO = LHR_W;
  localparam int S_GH_HI = LHR_W + GHIST_W - 1;

  logic rst_q_n;

  tp_rst_sync u_rst (.clk(clk), .rst_n_i(rst_n), .rst_n_o(rst_q_n));

  // snapshot fields on the update side
  logic               up_pred, up_gpred, up_lpred, up_mispredict;
  logic [GHIST_W-1:0] up_ghist;
  logic [LHR_W-1:0]   up_lhist;

  assign up_pred       = up_snap[S_PRED];
  assign up_gpred      = up_snap[S_GLOB];
  assign up_lpred      = up_snap[S_LOC];
  assign up_ghist      = up_snap[S_GH_HI:S_GH_LO];
  assign up_lhist      = up_snap[LHR_W-1:0];
  assign up_mispredict = up_valid & (up_pred != up_taken);

  // global history
  logic [GHIST_W-1:0] ghist_q;

  tp_global_hist #(.HIST_W(GHIST_W)) u_ghist (
    .clk(clk), .rst_n(rst_q_n),
    .shift_en(lk_valid), .shift_bit(lk_taken),
    .repair_en(up_mispredict), .repair_base(up_ghist[GHIST_W-2:0]),
    .repair_bit(up_taken), .hist_o(ghist_q)
  );

  // fold history to table index width
  logic [PHT_IW-1:0] lk_hfold, up_hfold;

  generate
    if (GHIST_W >= PHT_IW) begin : g_trunc
      assign lk_hfold = ghist_q[PHT_IW-1:0];
      assign up_hfold = up_ghist[PHT_IW-1:0];
    end else begin : g_zext
      assign lk_hfold = {{(PHT_IW-GHIST_W){1'b0}}, ghist_q};
      assign up_hfold = {{(PHT_IW-GHIST_W){1'b0}}, up_ghist};
    end
  endgenerate

  logic [PHT_IW-1:0] lk_gidx, up_gidx;
  logic [LHR_IW-1:0] lk_lidx, up_lidx;
  logic [CH_IW-1:0]  lk_cidx, up_cidx;

  assign lk_gidx = lk_hfold ^ lk_pc[PHT_IW+1:2];
  assign up_gidx = up_hfold ^ up_pc[PHT_IW+1:2];
  assign lk_lidx = lk_pc[LHR_IW+1:2];
  assign up_lidx = up_pc[LHR_IW+1:2];
  assign lk_cidx = lk_pc[CH_IW+1:2];
  assign up_cidx = up_pc[CH_IW+1:2];

  // global component
  ctr_t gctr;

  tp_ctr_table #(.ENTRIES(PHT_ENTRIES)) u_gpht (
    .clk(clk), .rst_n(rst_q_n),
    .rd_idx(lk_gidx), .rd_ctr(gctr),
    .wr_en(up_valid), .wr_idx(up_gidx), .wr_up(up_taken)
  );

  // local component
  logic [LHR_W-1:0] lk_lhist;
  ctr_t             lctr;

  tp_local_hist #(.COUNT(LHR_COUNT), .HIST_W(LHR_W)) u_lhr (
    .clk(clk), .rst_n(rst_q_n),
    .rd_idx(lk_lidx), .rd_hist(lk_lhist),
    .wr_en(up_valid), .wr_idx(up_lidx), .wr_bit(up_taken)
  );

  tp_ctr_table #(.ENTRIES(LPHT_N)) u_lpht (
    .clk(clk), .rst_n(rst_q_n),
    .rd_idx(lk_lhist), .rd_ctr(lctr),
    .wr_en(up_valid), .wr_idx(up_lhist), .wr_up(up_taken)
  );

  // chooser: trained only on disagreement, toward the correct side
  ctr_t cctr;
  logic ch_train, ch_toward_glob;

  assign ch_train       = up_valid & (up_gpred != up_lpred);
  assign ch_toward_glob = (up_gpred == up_taken);

  tp_ctr_table #(.ENTRIES(CHOOSER_ENTRIES)) u_chsr (
    .clk(clk), .rst_n(rst_q_n),
    .rd_idx(lk_cidx), .rd_ctr(cctr),
    .wr_en(ch_train), .wr_idx(up_cidx), .wr_up(ch_toward_glob)
  );

  // final guess and snapshot
  logic lk_gpred, lk_lpred;

  assign lk_gpred = gctr[1];
  assign lk_lpred = lctr[1];
  assign lk_taken = cctr[1] ? lk_gpred : lk_lpred;
  assign lk_snap  = {lk_taken, lk_gpred, lk_lpred, ghist_q, lk_lhist};

  logic unused_bits;
  assign unused_bits = ^{lk_pc[PC_W-1:TOP_IW+2], lk_pc[1:0],
                         up_pc[PC_W-1:TOP_IW+2], up_pc[1:0],
                         gctr[0], lctr[0], cctr[0]};
endmodule

// File: rtl/tp_checker.sv
module tp_checker #(
  parameter int GHIST_W = 10
) (
  input logic               clk,
  input logic               rst_ni,
  input logic               lk_valid,
  input logic               lk_taken,
  input logic               up_valid,
  input logic               up_taken,
  input logic               up_pred,
  input logic [GHIST_W-2:0] up_ghist_tail,
  input logic [GHIST_W-1:0] ghist_q
);
  logic mispr;
  assign mispr = up_valid & (up_pred != up_taken);

  // R6: a live lookup without repair shifts the guess in
  a_r6_lookup_shift: assert property (@(posedge clk) disable iff (!rst_ni)
    (lk_valid && !mispr) |=> ghist_q == {$past(ghist_q[GHIST_W-2:0]), $past(lk_taken)});

  // R6: no lookup, no repair: history holds
  a_r6_hold_idle: assert property (@(posedge clk) disable iff (!rst_ni)
    (!lk_valid && !mispr) |=> $stable(ghist_q));

  // R9: repair rebuilds history from the snapshot
  a_r9_repair: assert property (@(posedge clk) disable iff (!rst_ni)
    (mispr && !lk_valid) |=> ghist_q == {$past(up_ghist_tail), $past(up_taken)});

  // R10: repair wins over a same-cycle lookup
  a_r10_repair_wins: assert property (@(posedge clk) disable iff (!rst_ni)
    (mispr && lk_valid) |=> ghist_q == {$past(up_ghist_tail), $past(up_taken)});
endmodule

bind tournament_predictor tp_checker #(.GHIST_W(GHIST_W)) u_chk (
  .clk(clk), .rst_ni(rst_q_n),
  .lk_valid(lk_valid), .lk_taken(lk_taken),
  .up_valid(up_valid), .up_taken(up_taken),
  .up_pred(up_snap[SNAP_W-1]),
  .up_ghist_tail(up_snap[LHR_W+GHIST_W-2:LHR_W]),
  .ghist_q(ghist_q)
);

// File: tb/tournament_predictor_test.sv
`timescale 1ns/1ps
module tournament_predictor_test;

  typedef struct packed {
    logic        lv;
    logic [31:0] lpc;
    logic        uv;
    logic [31:0] upc;
    logic        ut;
    logic [22:0] us;
    logic [22:0] em;
    logic [22:0] ev;
    logic [3:0]  rq;
  } row_t;

  localparam logic [22:0] MP   = 23'h400000;
  localparam logic [22:0] MG   = 23'h200000;
  localparam logic [22:0] ML   = 23'h100000;
  localparam logic [22:0] MGH  = 23'h0FFC00;
  localparam logic [22:0] MALL = 23'h7FFFFF;

  localparam logic [31:0] PA = 32'h10,  PC3 = 32'h30,  P1 = 32'h100, PF = 32'h200;
  localparam logic [31:0] PG = 32'h400, PH  = 32'h800, P4 = 32'h4;

  function automatic logic [22:0] mk(input logic p, input logic g, input logic l,
                                     input logic [9:0] gh, input logic [9:0] lh);
    return {p, g, l, gh, lh};
  endfunction

  localparam int NROW = 37;
  localparam row_t VEC [NROW] = '{
    '{1'b0, PA,  1'b0, 32'h0, 1'b0, mk(0,0,0,0,0),         MALL,        mk(0,0,0,0,0),       4'd1},  // R1
    '{1'b0, 32'h0, 1'b1, P1, 1'b1, mk(1,0,0,0,0),          23'h0,       23'h0,               4'd3},
    '{1'b0, PC3, 1'b0, 32'h0, 1'b0, 23'h0,                 MP|MG|ML,    mk(1,0,1,0,0),       4'd2},  // R2
    '{1'b0, 32'h0, 1'b1, P1, 1'b1, mk(1,0,0,0,0),          23'h0,       23'h0,               4'd3},
    '{1'b0, 32'h0, 1'b1, P1, 1'b1, mk(1,0,0,0,0),          23'h0,       23'h0,               4'd3},
    '{1'b0, 32'h0, 1'b1, P1, 1'b0, mk(0,0,0,0,0),          23'h0,       23'h0,               4'd3},
    '{1'b0, PC3, 1'b0, 32'h0, 1'b0, 23'h0,                 ML,          mk(0,0,1,0,0),       4'd3},  // R3 top hold
    '{1'b0, 32'h0, 1'b1, P1, 1'b0, mk(0,0,0,0,0),          23'h0,       23'h0,               4'd3},
    '{1'b0, PC3, 1'b0, 32'h0, 1'b0, 23'h0,                 ML,          mk(0,0,0,0,0),       4'd3},  // R3
    '{1'b0, 32'h0, 1'b1, PF, 1'b0, mk(0,0,0,0,10'h3FF),    23'h0,       23'h0,               4'd3},
    '{1'b0, 32'h0, 1'b1, PF, 1'b0, mk(0,0,0,0,10'h3FF),    23'h0,       23'h0,               4'd3},
    '{1'b0, 32'h0, 1'b1, PF, 1'b1, mk(1,0,0,0,10'h3FF),    23'h0,       23'h0,               4'd3},
    '{1'b0, 32'h0, 1'b1, PF, 1'b1, mk(1,0,0,0,10'h3FF),    23'h0,       23'h0,               4'd3},
    '{1'b0, PF,  1'b0, 32'h0, 1'b0, 23'h0,                 MALL,        mk(0,1,0,0,3),       4'd5},  // R5, R3 bottom hold
    '{1'b0, 32'h0, 1'b1, PF, 1'b1, mk(1,1,0,0,10'h3FF),    23'h0,       23'h0,               4'd7},
    '{1'b0, PF,  1'b0, 32'h0, 1'b0, 23'h0,                 MALL,        mk(1,1,0,0,7),       4'd7},  // R7 toward global
    '{1'b0, 32'h0, 1'b1, PF, 1'b0, mk(0,1,1,1,10'h3FF),    23'h0,       23'h0,               4'd8},
    '{1'b0, 32'h0, 1'b1, PF, 1'b0, mk(0,1,1,1,10'h3FF),    23'h0,       23'h0,               4'd8},
    '{1'b0, PF,  1'b0, 32'h0, 1'b0, 23'h0,                 MALL,        mk(1,1,0,0,10'h1C),  4'd8},  // R8
    '{1'b0, 32'h0, 1'b1, PF, 1'b0, mk(0,1,0,2,10'h3FF),    23'h0,       23'h0,               4'd7},
    '{1'b0, 32'h0, 1'b1, PF, 1'b0, mk(0,1,0,2,10'h3FF),    23'h0,       23'h0,               4'd7},
    '{1'b0, PF,  1'b0, 32'h0, 1'b0, 23'h0,                 MALL,        mk(0,1,0,0,10'h70),  4'd7},  // R7 toward local
    '{1'b0, 32'h0, 1'b1, PG, 1'b1, mk(0,0,0,10'h155,10'h3FF), 23'h0,    23'h0,               4'd9},
    '{1'b0, PA,  1'b0, 32'h0, 1'b0, 23'h0,                 MGH,         mk(0,0,0,10'h2AB,0), 4'd9},  // R9
    '{1'b1, PA,  1'b0, 32'h0, 1'b0, 23'h0,                 MP|MGH,      mk(0,0,0,10'h2AB,0), 4'd6},
    '{1'b0, PA,  1'b0, 32'h0, 1'b0, 23'h0,                 MGH,         mk(0,0,0,10'h156,0), 4'd6},  // R6 shift of 0
    '{1'b0, 32'h0, 1'b1, PH, 1'b1, mk(1,0,0,0,0),          23'h0,       23'h0,               4'd6},
    '{1'b0, 32'h0, 1'b1, PH, 1'b1, mk(1,0,0,0,0),          23'h0,       23'h0,               4'd6},
    '{1'b1, PA,  1'b0, 32'h0, 1'b0, 23'h0,                 MALL,        mk(1,0,1,10'h156,0), 4'd6},
    '{1'b0, PA,  1'b0, 32'h0, 1'b0, 23'h0,                 MGH,         mk(0,0,0,10'h2AD,0), 4'd6},  // R6 shift of 1
    '{1'b1, PA,  1'b1, PG, 1'b0, mk(1,0,0,0,10'h3FF),      MP,          mk(1,0,0,0,0),       4'd10},
    '{1'b0, PA,  1'b0, 32'h0, 1'b0, 23'h0,                 MGH,         mk(0,0,0,0,0),       4'd10}, // R10
    '{1'b0, 32'h0, 1'b1, PH, 1'b0, mk(0,0,0,0,0),          23'h0,       23'h0,               4'd11},
    '{1'b0, PA,  1'b1, PH, 1'b0, mk(0,0,0,0,0),            ML,          mk(0,0,1,0,0),       4'd11}, // R11 pre-update
    '{1'b0, PA,  1'b0, 32'h0, 1'b0, 23'h0,                 ML,          mk(0,0,0,0,0),       4'd11}, // R11 after edge
    '{1'b0, 32'h0, 1'b1, PG, 1'b1, mk(0,0,0,10'h040,10'h3FF), 23'h0,    23'h0,               4'd4},
    '{1'b0, P4,  1'b0, 32'h0, 1'b0, 23'h0,                 MG,          mk(0,1,0,0,0),       4'd4}   // R4 XOR index
  };

  logic        clk, rst_n;
  logic        lk_valid, up_valid, up_taken, lk_taken;
  logic [31:0] lk_pc, up_pc;
  logic [22:0] lk_snap, up_snap;
  int          n_checks, n_errors;
  bit          done;

  tournament_predictor uut (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_pc(lk_pc), .lk_taken(lk_taken), .lk_snap(lk_snap),
    .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken), .up_snap(up_snap)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input int rq, input logic [22:0] m,
                       input logic [22:0] act, input logic [22:0] exp);
    n_checks++;
    if ((act & m) !== (exp & m)) begin
      n_errors++;
      $display("FAIL R%0d actual=%h expected=%h (mask %h)", rq, act & m, exp & m, m);
    end
  endtask

  task automatic idle_inputs();
    lk_valid = 1'b0; lk_pc = '0; up_valid = 1'b0; up_pc = '0; up_taken = 1'b0; up_snap = '0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    n_checks = 0; n_errors = 0; done = 1'b0;
    rst_n = 1'b0;
    idle_inputs();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // vector table walk
    for (int i = 0; i < NROW; i++) begin
      @(negedge clk);
      lk_valid = VEC[i].lv;  lk_pc   = VEC[i].lpc;
      up_valid = VEC[i].uv;  up_pc   = VEC[i].upc;
      up_taken = VEC[i].ut;  up_snap = VEC[i].us;
      #1;
      if (VEC[i].em != '0) begin
        check(int'(VEC[i].rq), VEC[i].em, lk_snap, VEC[i].ev);
        if (VEC[i].em[22]) check(2, 23'h1, {22'h0, lk_taken}, {22'h0, VEC[i].ev[22]}); // R2 port
      end
    end

    // directed: reset in the middle of a trained state (R1)
    @(negedge clk);
    idle_inputs();
    rst_n = 1'b0;
    #1;
    lk_pc = PF;
    #1;
    check(1, MALL, lk_snap, mk(0,0,0,0,0));   // R1 async clear
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    lk_pc = P4;
    #1;
    check(1, MALL, lk_snap, mk(0,0,0,0,0));   // R1 after release
    check(1, 23'h1, {22'h0, lk_taken}, 23'h0);

    // directed: idle lookup does not move history (R6)
    @(negedge clk);
    lk_pc = PA;
    #1;
    check(6, MGH, lk_snap, mk(0,0,0,0,0));

    done = 1'b1;
    finish_run();
  end
endmodule